// File: doc/BRIEF.md
# Rotating Register Stack

This block holds eight 80-bit value registers that software sees as a stack. Every register is named relative to a movable top pointer, and each register carries an empty tag. Commands arrive one per clock. They can push a word, pop the top word, read any stack slot, swap the top with another slot, or mark a slot empty. Other commands nudge the pointer up or down, or reinitialize the whole stack. Exchange, free and pointer moves never copy data between registers except where a swap demands it.

For two-operand arithmetic the block is only a router. It shows two operand words to an external datapath in the same cycle as the command, and it takes the result word back on that clock edge. Three flags shape the routing. A direction flag picks whether the top slot or slot n receives the result. A reverse flag swaps which word is shown as the first operand. A pop flag retires the top slot after the write. Misuse sets a sticky fault flag and leaves the registers untouched. Misuse means pushing onto an occupied register, or popping or reading an empty one, or giving arithmetic an empty operand.

Top module: `fpstack_core`

## Requirements
- R1: After reset, and on the cycle after an init command (op 8), top_ptr is 0, all eight bits of tags_empty are 1 (bit i is the tag of physical register i) and fault is 0. Reset also clears the register data to zero; init does not touch data.
- R2: A push (op 1) whose target register is empty first lowers top_ptr by one modulo 8. It then writes push_data into the new top and clears that register's tag. Slot ST(i) always maps to physical register (top_ptr + i) mod 8.
- R3: A push whose target register (top_ptr - 1 mod 8) is not empty sets fault and changes neither top_ptr, tags nor data.
- R4: A read (op 3) of ST(cmd_idx) puts that word on rd_data with rd_valid high on the cycle after the command. The stack is left unchanged.
- R5: A pop (op 2) of a non-empty top shows the old ST on rd_data with rd_valid high. It then marks that register empty and raises top_ptr by one modulo 8.
- R6: A pop or read of an empty slot sets fault and leaves top_ptr and tags unchanged. rd_data still shows the word held in that register.
- R7: An exchange (op 4) between ST and ST(cmd_idx), both full, swaps their contents. An exchange with an empty slot sets fault.
- R8: A free (op 5) marks the tag of ST(cmd_idx) empty and changes neither its data nor top_ptr.
- R9: Pointer increment (op 6) and decrement (op 7) change top_ptr by +1 and -1 modulo 8 and leave tags and data alone.
- R10: During an arithmetic command (op 9), with cmd_rev 0, opa shows the destination slot and opb the other slot. The destination is ST when cmd_dir is 0 and ST(cmd_idx) when cmd_dir is 1. With cmd_rev 1 the two outputs are swapped. res_data is written into the destination on that edge.
- R11: For an arithmetic command with cmd_dir 1 and cmd_pop 1, the top register is marked empty after the write and top_ptr rises by one. With cmd_dir 0, cmd_pop has no effect.
- R12: An arithmetic command with ST or ST(cmd_idx) empty sets fault and writes nothing.
- R13: fault, once set, stays set through later commands until reset or init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_idx | input | 3 | Relative slot n of ST(n) |
| cmd_dir | input | 1 | Arithmetic destination: 0 ST, 1 ST(n) |
| cmd_rev | input | 1 | Arithmetic operand swap |
| cmd_pop | input | 1 | Arithmetic pop of ST after write |
| push_data | input | 80 | Word for a push |
| res_data | input | 80 | Result word from the external datapath |
| opa | output | 80 | First arithmetic operand |
| opb | output | 80 | Second arithmetic operand |
| rd_data | output | 80 | Word from the last read or pop |
| rd_valid | output | 1 | rd_data was loaded by the previous command |
| top_ptr | output | 3 | Physical index of the current top |
| tags_empty | output | 8 | Empty tag per physical register |
| fault | output | 1 | Sticky stack fault |

## Verification
The hardest state to reach is a stack whose pointer has wrapped past zero while registers on both sides of the wrap are full. That state is needed for overflow, and for showing that ST(i) indexing and exchange work across the boundary. The stimulus fills all eight registers so the top lands back on physical 0, then pushes once more. It also builds a partly filled stack, then swaps and frees slots inside it. A freed slot is read back so that its kept data shows up on rd_data while fault rises. The arithmetic scenario chains four results through the stack and covers each direction and reverse combination.

// File: rtl/fpstack_pkg.sv
package fpstack_pkg;
    localparam int DATA_W = 80;
    localparam int DEPTH  = 8;
    localparam int PTR_W  = $clog2(DEPTH);

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PUSH  = 4'd1,
        OP_POP   = 4'd2,
        OP_READ  = 4'd3,
        OP_XCHG  = 4'd4,
        OP_FREE  = 4'd5,
        OP_INCP  = 4'd6,
        OP_DECP  = 4'd7,
        OP_INIT  = 4'd8,
        OP_ARITH = 4'd9
    } op_e;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    function automatic logic [PTR_W-1:0] rel_to_phys(input logic [PTR_W-1:0] top,
                                                     input logic [PTR_W-1:0] rel);
        return top + rel;
    endfunction
endpackage

// File: rtl/fpstack_regfile.sv
module fpstack_regfile
    import fpstack_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  wr_t                          wa,
    input  wr_t                          wb,
    input  logic [DEPTH-1:0]             tag_fill,
    input  logic [DEPTH-1:0]             tag_clr,
    input  logic                         tag_init,
    output logic [DEPTH-1:0][DATA_W-1:0] q,
    output logic [DEPTH-1:0]             empty
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (wa.en && wa.addr == PTR_W'(i)) begin
                q[i] <= wa.data;
            end else if (wb.en && wb.addr == PTR_W'(i)) begin
                q[i] <= wb.data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || tag_init) begin
                empty[i] <= 1'b1;
            end else if (tag_clr[i]) begin
                empty[i] <= 1'b1;
            end else if (tag_fill[i]) begin
                empty[i] <= 1'b0;
            end
        end
    end

    // R7
    dual_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wa.en && wb.en && wa.addr == wb.addr) |-> (wa.data == wb.data));

    // R1
    init_tags_chk: assert property (@(posedge clk) disable iff (rst)
        tag_init |=> (&empty));
endmodule

// File: rtl/fpstack_route.sv
module fpstack_route
    import fpstack_pkg::*;
(
    input  logic [PTR_W-1:0]             top,
    input  logic [PTR_W-1:0]             idx,
    input  logic                         dir,
    input  logic                         rev,
    input  logic [DEPTH-1:0][DATA_W-1:0] q,
    input  logic [DEPTH-1:0]             empty,
    output logic [PTR_W-1:0]             n_addr,
    output logic [PTR_W-1:0]             dest_addr,
    output logic                         ops_full,
    output logic [DATA_W-1:0]            opa,
    output logic [DATA_W-1:0]            opb
);
    logic [PTR_W-1:0]  other_addr;
    logic [DATA_W-1:0] dest_word;
    logic [DATA_W-1:0] other_word;

    always_comb begin
        n_addr     = rel_to_phys(top, idx);
        dest_addr  = dir ? n_addr : top;
        other_addr = dir ? top : n_addr;
        dest_word  = q[dest_addr];
        other_word = q[other_addr];
        opa        = rev ? other_word : dest_word;
        opb        = rev ? dest_word  : other_word;
        ops_full   = !empty[top] && !empty[n_addr];
    end
endmodule

// File: rtl/fpstack_ctrl.sv
module fpstack_ctrl
    import fpstack_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         valid,
    input  op_e                          op,
    input  logic                         dir,
    input  logic                         pop,
    input  logic [DATA_W-1:0]            push_data,
    input  logic [DATA_W-1:0]            res_data,
    input  logic [DEPTH-1:0][DATA_W-1:0] q,
    input  logic [DEPTH-1:0]             empty,
    input  logic [PTR_W-1:0]             n_addr,
    input  logic [PTR_W-1:0]             dest_addr,
    input  logic                         ops_full,
    output logic [PTR_W-1:0]             top,
    output wr_t                          wa,
    output wr_t                          wb,
    output logic [DEPTH-1:0]             tag_fill,
    output logic [DEPTH-1:0]             tag_clr,
    output logic                         tag_init,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_valid,
    output logic                         fault
);
    logic [PTR_W-1:0] push_addr;
    logic [PTR_W-1:0] top_inc;
    logic [PTR_W-1:0] top_nx;
    logic [PTR_W-1:0] rd_sel;
    logic             rd_load;
    logic             fault_set;

    always_comb begin
        push_addr = top - PTR_W'(1);
        top_inc   = top + PTR_W'(1);
        wa        = '{en: 1'b0, addr: top, data: res_data};
        wb        = '{en: 1'b0, addr: n_addr, data: q[top]};
        tag_fill  = '0;
        tag_clr   = '0;
        tag_init  = 1'b0;
        top_nx    = top;
        fault_set = 1'b0;
        rd_load   = 1'b0;
        rd_sel    = n_addr;
        if (valid) begin
            unique case (op)
                OP_PUSH: begin
                    if (empty[push_addr]) begin
                        wa                  = '{en: 1'b1, addr: push_addr, data: push_data};
                        tag_fill[push_addr] = 1'b1;
                        top_nx              = push_addr;
                    end else begin
                        fault_set = 1'b1;
                    end
                end
                OP_POP: begin
                    rd_load = 1'b1;
                    rd_sel  = top;
                    if (empty[top]) begin
                        fault_set = 1'b1;
                    end else begin
                        tag_clr[top] = 1'b1;
                        top_nx       = top_inc;
                    end
                end
                OP_READ: begin
                    rd_load   = 1'b1;
                    fault_set = empty[n_addr];
                end
                OP_XCHG: begin
                    if (ops_full) begin
                        wa = '{en: 1'b1, addr: top, data: q[n_addr]};
                        wb = '{en: 1'b1, addr: n_addr, data: q[top]};
                    end else begin
                        fault_set = 1'b1;
                    end
                end
                OP_FREE:  tag_clr[n_addr] = 1'b1;
                OP_INCP:  top_nx = top_inc;
                OP_DECP:  top_nx = push_addr;
                OP_INIT:  tag_init = 1'b1;
                OP_ARITH: begin
                    if (ops_full) begin
                        wa = '{en: 1'b1, addr: dest_addr, data: res_data};
                        if (dir && pop) begin
                            tag_clr[top] = 1'b1;
                            top_nx       = top_inc;
                        end
                    end else begin
                        fault_set = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || tag_init) begin
            top   <= '0;
            fault <= 1'b0;
        end else begin
            top   <= top_nx;
            fault <= fault | fault_set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_load;
            if (rd_load) begin
                rd_data <= q[rd_sel];
            end
        end
    end

    // R2
    push_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && op == OP_PUSH && empty[push_addr]) |=> (top == PTR_W'($past(top) - 1)));

    // R3
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && op == OP_PUSH && !empty[push_addr]) |=> (fault && top == $past(top)));

    // R13
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !(valid && op == OP_INIT)) |=> fault);

    // R8
    free_top_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && op == OP_FREE) |=> (top == $past(top)));

    // R9
    ptr_tags_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (op == OP_INCP || op == OP_DECP)) |=> (empty == $past(empty)));
endmodule

// File: rtl/fpstack_core.sv
module fpstack_core
    import fpstack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [PTR_W-1:0]  cmd_idx,
    input  logic              cmd_dir,
    input  logic              cmd_rev,
    input  logic              cmd_pop,
    input  logic [DATA_W-1:0] push_data,
    input  logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [PTR_W-1:0]  top_ptr,
    output logic [DEPTH-1:0]  tags_empty,
    output logic              fault
);
    logic [DEPTH-1:0][DATA_W-1:0] q;
    logic [DEPTH-1:0]             empty;
    logic [PTR_W-1:0]             top;
    logic [PTR_W-1:0]             n_addr;
    logic [PTR_W-1:0]             dest_addr;
    logic                         ops_full;
    wr_t                          wa;
    wr_t                          wb;
    logic [DEPTH-1:0]             tag_fill;
    logic [DEPTH-1:0]             tag_clr;
    logic                         tag_init;
    op_e                          op;

    assign op         = op_e'(cmd_op);
    assign top_ptr    = top;
    assign tags_empty = empty;

    fpstack_regfile i_regfile (
        .clk      (clk),
        .rst      (rst),
        .wa       (wa),
        .wb       (wb),
        .tag_fill (tag_fill),
        .tag_clr  (tag_clr),
        .tag_init (tag_init),
        .q        (q),
        .empty    (empty)
    );

    fpstack_route i_route (
        .top       (top),
        .idx       (cmd_idx),
        .dir       (cmd_dir),
        .rev       (cmd_rev),
        .q         (q),
        .empty     (empty),
        .n_addr    (n_addr),
        .dest_addr (dest_addr),
        .ops_full  (ops_full),
        .opa       (opa),
        .opb       (opb)
    );

    fpstack_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .valid     (cmd_valid),
        .op        (op),
        .dir       (cmd_dir),
        .pop       (cmd_pop),
        .push_data (push_data),
        .res_data  (res_data),
        .q         (q),
        .empty     (empty),
        .n_addr    (n_addr),
        .dest_addr (dest_addr),
        .ops_full  (ops_full),
        .top       (top),
        .wa        (wa),
        .wb        (wb),
        .tag_fill  (tag_fill),
        .tag_clr   (tag_clr),
        .tag_init  (tag_init),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .fault     (fault)
    );

    // R12
    arith_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_ARITH && (empty[top] || empty[n_addr])) |=> fault);

    // R11
    arith_nopop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_ARITH && !cmd_dir) |=> (top == $past(top)));
endmodule

// File: tb/test_fpstack_core.sv
`timescale 1ns/1ps
module test_fpstack_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [2:0]  cmd_idx = 3'd0;
    logic        cmd_dir = 1'b0;
    logic        cmd_rev = 1'b0;
    logic        cmd_pop = 1'b0;
    logic [79:0] push_data = '0;
    logic [79:0] res_data = '0;
    logic [79:0] opa, opb, rd_data;
    logic        rd_valid, fault;
    logic [2:0]  top_ptr;
    logic [7:0]  tags_empty;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] PUSH = 4'd1, POP = 4'd2, READ = 4'd3, XCHG = 4'd4,
                           FREE = 4'd5, INCP = 4'd6, DECP = 4'd7, INIT = 4'd8,
                           ARITH = 4'd9;

    always #2.5 clk = ~clk;

    fpstack_core i_fpstack_core (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_dir(cmd_dir), .cmd_rev(cmd_rev), .cmd_pop(cmd_pop),
        .push_data(push_data), .res_data(res_data), .opa(opa), .opb(opb),
        .rd_data(rd_data), .rd_valid(rd_valid), .top_ptr(top_ptr),
        .tags_empty(tags_empty), .fault(fault)
    );

    task automatic chk(input string what, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] op, input logic [2:0] idx,
                       input logic [79:0] pd);
        @(negedge clk);
        cmd_op = op; cmd_idx = idx; push_data = pd;
        cmd_dir = 1'b0; cmd_rev = 1'b0; cmd_pop = 1'b0;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_chk(input string what, input logic [2:0] idx, input logic [79:0] exp);
        cmd(READ, idx, '0);
        chk({what, " rd_valid"}, 80'(rd_valid), 80'd1);
        chk(what, rd_data, exp);
    endtask

    task automatic arith(input string what, input logic [2:0] idx, input logic dir,
                         input logic rev, input logic pop, input logic [79:0] res,
                         input logic [79:0] ea, input logic [79:0] eb);
        @(negedge clk);
        cmd_op = ARITH; cmd_idx = idx; cmd_dir = dir; cmd_rev = rev; cmd_pop = pop;
        res_data = res; cmd_valid = 1'b1;
        #1;
        chk({what, " opa"}, opa, ea);
        chk({what, " opb"}, opb, eb);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset top", 80'(top_ptr), 80'd0);
        chk("R1 reset tags", 80'(tags_empty), 80'hFF);
        chk("R1 reset fault", 80'(fault), 80'd0);
    endtask

    task automatic t_pop();
        cmd(INIT, 0, '0);
        cmd(PUSH, 0, 80'hA1);
        cmd(PUSH, 0, 80'hB2);
        cmd(POP, 0, '0);
        chk("R5 pop data", rd_data, 80'hB2);
        chk("R5 pop valid", 80'(rd_valid), 80'd1);
        chk("R5 pop top", 80'(top_ptr), 80'd7);
        chk("R5 pop tags", 80'(tags_empty), 80'h7F);
        cmd(POP, 0, '0);
        chk("R5 pop2 data", rd_data, 80'hA1);
        chk("R5 pop2 top", 80'(top_ptr), 80'd0);
        chk("R6 no fault yet", 80'(fault), 80'd0);
        cmd(POP, 0, '0);
        chk("R6 pop empty fault", 80'(fault), 80'd1);
        chk("R6 pop empty top", 80'(top_ptr), 80'd0);
        chk("R6 pop empty tags", 80'(tags_empty), 80'hFF);
        chk("R6 pop empty data", rd_data, 80'd0);
    endtask

    task automatic t_overflow();
        cmd(INIT, 0, '0);
        chk("R1 init clears fault", 80'(fault), 80'd0);
        for (int i = 0; i < 8; i++) cmd(PUSH, 0, 80'(i + 1));
        chk("R2 full top wrap", 80'(top_ptr), 80'd0);
        chk("R2 full tags", 80'(tags_empty), 80'h00);
        chk("R2 no fault", 80'(fault), 80'd0);
        cmd(PUSH, 0, 80'hDEAD);
        chk("R3 overflow fault", 80'(fault), 80'd1);
        chk("R3 overflow top", 80'(top_ptr), 80'd0);
        read_chk("R4 R3 ST0 kept", 0, 80'd8);
        read_chk("R3 ST7 kept", 7, 80'd1);
        read_chk("R2 ST3", 3, 80'd5);
        chk("R4 read top", 80'(top_ptr), 80'd0);
    endtask

    task automatic t_xchg_free();
        cmd(INIT, 0, '0);
        cmd(PUSH, 0, 80'hAA);
        cmd(PUSH, 0, 80'hBB);
        cmd(PUSH, 0, 80'hCC);
        chk("R2 top after 3", 80'(top_ptr), 80'd5);
        chk("R2 tags after 3", 80'(tags_empty), 80'h1F);
        cmd(XCHG, 2, '0);
        read_chk("R7 ST0 after xchg", 0, 80'hAA);
        read_chk("R7 ST2 after xchg", 2, 80'hCC);
        read_chk("R7 ST1 untouched", 1, 80'hBB);
        chk("R7 no fault", 80'(fault), 80'd0);
        cmd(FREE, 1, '0);
        chk("R8 free tags", 80'(tags_empty), 80'h5F);
        chk("R8 free top", 80'(top_ptr), 80'd5);
        cmd(READ, 1, '0);
        chk("R8 R6 freed data kept", rd_data, 80'hBB);
        chk("R6 read empty fault", 80'(fault), 80'd1);
        chk("R6 read empty tags", 80'(tags_empty), 80'h5F);
        cmd(READ, 0, '0);
        chk("R13 fault sticky", 80'(fault), 80'd1);
        cmd(INIT, 0, '0);
        chk("R1 init fault", 80'(fault), 80'd0);
        chk("R1 init tags", 80'(tags_empty), 80'hFF);
        chk("R1 init top", 80'(top_ptr), 80'd0);
        cmd(PUSH, 0, 80'h11);
        cmd(XCHG, 3, '0);
        chk("R7 xchg empty fault", 80'(fault), 80'd1);
    endtask

    task automatic t_ptr();
        cmd(INIT, 0, '0);
        cmd(DECP, 0, '0);
        chk("R9 decp top", 80'(top_ptr), 80'd7);
        chk("R9 decp tags", 80'(tags_empty), 80'hFF);
        cmd(INCP, 0, '0);
        cmd(INCP, 0, '0);
        chk("R9 incp top", 80'(top_ptr), 80'd1);
        chk("R9 incp tags", 80'(tags_empty), 80'hFF);
        chk("R9 no fault", 80'(fault), 80'd0);
    endtask

    task automatic t_arith();
        cmd(INIT, 0, '0);
        cmd(PUSH, 0, 80'd10);
        cmd(PUSH, 0, 80'd3);
        arith("R10 dir1", 1, 1'b1, 1'b0, 1'b1, 80'd7, 80'd10, 80'd3);
        chk("R11 pop top", 80'(top_ptr), 80'd7);
        chk("R11 pop tags", 80'(tags_empty), 80'h7F);
        read_chk("R11 result at new top", 0, 80'd7);
        cmd(PUSH, 0, 80'd4);
        arith("R10 dir0 rev", 1, 1'b0, 1'b1, 1'b1, 80'd100, 80'd7, 80'd4);
        chk("R11 pop ignored dir0 top", 80'(top_ptr), 80'd6);
        chk("R11 pop ignored dir0 tags", 80'(tags_empty), 80'h3F);
        read_chk("R10 dest ST", 0, 80'd100);
        read_chk("R10 ST1 untouched", 1, 80'd7);
        arith("R10 dir0", 1, 1'b0, 1'b0, 1'b0, 80'd55, 80'd100, 80'd7);
        read_chk("R10 dir0 result", 0, 80'd55);
        arith("R10 dir1 rev", 1, 1'b1, 1'b1, 1'b0, 80'd9, 80'd55, 80'd7);
        read_chk("R10 dir1 dest ST1", 1, 80'd9);
        read_chk("R10 dir1 ST0 kept", 0, 80'd55);
        chk("R12 no fault yet", 80'(fault), 80'd0);
        @(negedge clk);
        cmd_op = ARITH; cmd_idx = 3'd5; cmd_dir = 1'b0; cmd_rev = 1'b0; cmd_pop = 1'b0;
        res_data = 80'd999; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R12 empty operand fault", 80'(fault), 80'd1);
        chk("R12 top unchanged", 80'(top_ptr), 80'd6);
        read_chk("R12 no write", 0, 80'd55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pop();
        t_overflow();
        t_xchg_free();
        t_ptr();
        t_arith();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule